// File: doc/BRIEF.md
# Multi-Match Timer Bank with Preload

The block holds a set of independent up-counters (three by default, 32 bits each) that advance on a slow function clock. Each counter is compared against three match values. A match sets a sticky status flag for that comparator, and a per-counter selector can name one comparator whose match reloads the counter from a preload value instead of letting it step on. A per-counter interrupt line is raised while any flagged comparator is also enabled.

Software reaches the bank through a simple word-addressed register port on a separate, faster bus clock. The live count is never read across the clock boundary directly. Software writes a request into a per-counter capture register. A toggle handshake carries the request into the counter domain, freezes a snapshot there, and carries an acknowledge back. The bus side then loads the frozen value, and reading the capture register returns it until the next request completes.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register address reads 0, every capture register reads 0 and every `irq` bit is low.
- R2: A counter adds one on each rising `fn_clk` edge while its bit in the enable register (bit t for counter t) is 1. It keeps its value while that bit is 0.
- R3: The 2-bit reload selector of a counter works as follows. Value 0 means no reload. Value k (1 to 3) names comparator k-1. When an enabled counter equals the named match value, its next value is the preload value instead of count+1.
- R4: A counter that is not reloaded steps from all ones to 0.
- R5: Comparator c of counter t sets bit c of that counter's status register when the enabled counter equals its match value. The bit stays set until a write to that counter's clear register with bit c = 1. Clear-register bits written as 0 leave their flags unchanged.
- R6: `irq[t]` is high exactly when some status bit of counter t is 1 and the same bit of its interrupt-enable register is also 1.
- R7: Writing a value with bit 0 = 1 to capture register t requests a snapshot. Once the handshake completes, reads of that register return the count taken in the counter domain, and the value holds until the next request completes. Writes with bit 0 = 0 do nothing.
- R8: Enabling, configuring or running one counter does not change the count of any other counter.
- R9: Word address map and field widths:
  - match registers: 0 to 8, with counter t comparator c at address t*3+c, 32 bits;
  - preload: 9 to 11, 32 bits;
  - reload selector: 12 to 14, 2 bits;
  - enable: 15, bits 2:0;
  - status: 16 to 18, read-only, 3 bits, writes ignored;
  - interrupt enable: 19 to 21, 3 bits;
  - clear: 22 to 24, reads 0;
  - capture: 25 to 27.
  
  Configuration registers read back their value masked to their width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, register side |
| fn_clk | input | 1 | Counter function clock, slower than bus_clk |
| fn_rst_n | input | 1 | Active-low asynchronous reset, counter side |
| reg_we | input | 1 | Write strobe, sampled on bus_clk |
| reg_addr | input | 6 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 3 | Per-counter interrupt line |

## Verification
The assertions assume `fn_clk` is several times slower than `bus_clk`. They also assume that match, preload and reload-selector values change only while the counter that uses them is stopped. Under those conditions each counter-domain event toggle is seen by the bus side before it can flip again, and the step and reload properties can sample configuration as steady. The bench runs the function clock at one eighth of the bus rate. It writes all counter configuration before setting a counter's enable bit, and clears that bit before any reconfiguration.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

   localparam int unsigned BUS_W = 32;

   typedef enum logic [3:0] {
      RG_MATCH,
      RG_PRELOAD,
      RG_RSEL,
      RG_ENABLE,
      RG_STATUS,
      RG_IEN,
      RG_ICLR,
      RG_CAPTURE,
      RG_NONE
   } reg_region_e;

endpackage

// File: rtl/tmr_bank_tsync.sv
module tmr_bank_tsync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          PULSE_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_bank_tsync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_in};
   end

   if (PULSE_OUT) begin : g_pulse
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q <= 1'b0;
         else        last_q <= chain[STAGES-1];
      end
      assign q_out = chain[STAGES-1] ^ last_q;
   end else begin : g_level
      assign q_out = chain[STAGES-1];
   end

endmodule

// File: rtl/tmr_bank_chan.sv
module tmr_bank_chan #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned N_CMP = 3,
   parameter int unsigned SEL_W = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic                            snap_req,
   input  logic [N_CMP-1:0][CNT_W-1:0]     match_vals,
   input  logic [CNT_W-1:0]                preload,
   input  logic [SEL_W-1:0]                rsel,
   output logic [CNT_W-1:0]                cnt_q,
   output logic [CNT_W-1:0]                snap_q,
   output logic [N_CMP-1:0]                evt_tgl,
   output logic                            ack_tgl
);

   if ((1 << SEL_W) < N_CMP + 1) begin : g_bad_sel
      $error("tmr_bank_chan: SEL_W too narrow for N_CMP");
   end

   logic [N_CMP-1:0] hit;
   logic             reload;

   for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
      assign hit[c] = run && (cnt_q == match_vals[c]);
   end

   always_comb begin
      reload = 1'b0;
      for (int c = 0; c < N_CMP; c++) begin
         if ((rsel == SEL_W'(c + 1)) && hit[c]) reload = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= reload ? preload : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_tgl <= '0;
      else        evt_tgl <= evt_tgl ^ hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q  <= '0;
         ack_tgl <= 1'b0;
      end else if (snap_req) begin
         snap_q  <= cnt_q;
         ack_tgl <= ~ack_tgl;
      end
   end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_bank_pkg::*;
#(
   parameter int unsigned N_TMR       = 3,
   parameter int unsigned N_CMP       = 3,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 6
) (
   input  logic              bus_clk,
   input  logic              bus_rst_n,
   input  logic              fn_clk,
   input  logic              fn_rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [N_TMR-1:0]  irq
);

   localparam int unsigned N_MATCH   = N_TMR * N_CMP;
   localparam int unsigned SEL_W     = $clog2(N_CMP + 1);
   localparam int unsigned PRE_BASE  = N_MATCH;
   localparam int unsigned SEL_BASE  = PRE_BASE + N_TMR;
   localparam int unsigned EN_ADDR   = SEL_BASE + N_TMR;
   localparam int unsigned STS_BASE  = EN_ADDR + 1;
   localparam int unsigned IEN_BASE  = STS_BASE + N_TMR;
   localparam int unsigned CLR_BASE  = IEN_BASE + N_TMR;
   localparam int unsigned CAP_BASE  = CLR_BASE + N_TMR;
   localparam int unsigned CAP_END   = CAP_BASE + N_TMR;

   if (CAP_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("tmr_bank: ADDR_W too small for the register map");
   end
   if (ADDR_W > 8) begin : g_bad_addr_w
      $error("tmr_bank: ADDR_W above 8 is not supported");
   end
   if ((CNT_W > BUS_W) || (N_TMR > BUS_W) || (N_CMP > BUS_W)) begin : g_bad_width
      $error("tmr_bank: a field is wider than the register port");
   end
   if ((N_TMR < 1) || (N_CMP < 1)) begin : g_bad_count
      $error("tmr_bank: N_TMR and N_CMP must be at least 1");
   end

   // ---------------- address decode ----------------
   reg_region_e dec_region;
   logic [7:0]  dec_idx;
   logic [31:0] addr_w;

   assign addr_w = 32'(reg_addr);

   always_comb begin
      dec_region = RG_NONE;
      dec_idx    = '0;
      if (addr_w < PRE_BASE) begin
         dec_region = RG_MATCH;
         dec_idx    = 8'(addr_w);
      end else if (addr_w < SEL_BASE) begin
         dec_region = RG_PRELOAD;
         dec_idx    = 8'(addr_w - PRE_BASE);
      end else if (addr_w < EN_ADDR) begin
         dec_region = RG_RSEL;
         dec_idx    = 8'(addr_w - SEL_BASE);
      end else if (addr_w == EN_ADDR) begin
         dec_region = RG_ENABLE;
      end else if (addr_w < IEN_BASE) begin
         dec_region = RG_STATUS;
         dec_idx    = 8'(addr_w - STS_BASE);
      end else if (addr_w < CLR_BASE) begin
         dec_region = RG_IEN;
         dec_idx    = 8'(addr_w - IEN_BASE);
      end else if (addr_w < CAP_BASE) begin
         dec_region = RG_ICLR;
         dec_idx    = 8'(addr_w - CLR_BASE);
      end else if (addr_w < CAP_END) begin
         dec_region = RG_CAPTURE;
         dec_idx    = 8'(addr_w - CAP_BASE);
      end
   end

   // ---------------- register state ----------------
   logic [N_MATCH-1:0][CNT_W-1:0] match_q;
   logic [N_TMR-1:0][CNT_W-1:0]   preload_q;
   logic [N_TMR-1:0][SEL_W-1:0]   rsel_q;
   logic [N_TMR-1:0]              en_q;
   logic [N_TMR-1:0][N_CMP-1:0]   ien_q;
   logic [N_TMR-1:0][N_CMP-1:0]   sts_q;
   logic [N_TMR-1:0][CNT_W-1:0]   cap_q;
   logic [N_TMR-1:0]              req_tgl;
   logic [N_TMR-1:0]              ack_seen;
   logic [N_TMR-1:0]              clr_wr;
   logic [N_TMR-1:0]              cap_wr;

   // crossing signals
   logic [N_TMR-1:0]              en_fn;
   logic [N_TMR-1:0]              req_pulse_fn;
   logic [N_TMR-1:0]              ack_tgl_fn;
   logic [N_TMR-1:0]              ack_pulse;
   logic [N_TMR-1:0][N_CMP-1:0]   evt_tgl_fn;
   logic [N_TMR-1:0][N_CMP-1:0]   evt_pulse;
   logic [N_TMR-1:0][CNT_W-1:0]   cnt_fn;
   logic [N_TMR-1:0][CNT_W-1:0]   snap_fn;

   for (genvar m = 0; m < N_MATCH; m++) begin : g_match
      logic match_wr;
      assign match_wr = reg_we && (dec_region == RG_MATCH) && (dec_idx == 8'(m));
      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
         if (!bus_rst_n)    match_q[m] <= '0;
         else if (match_wr) match_q[m] <= reg_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge bus_clk or negedge bus_rst_n) begin
      if (!bus_rst_n) begin
         en_q <= '0;
      end else if (reg_we && (dec_region == RG_ENABLE)) begin
         en_q <= reg_wdata[N_TMR-1:0];
      end
   end

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      logic pre_wr, sel_wr, ien_wr;
      logic [N_CMP-1:0][CNT_W-1:0] mv;

      assign pre_wr    = reg_we && (dec_region == RG_PRELOAD) && (dec_idx == 8'(t));
      assign sel_wr    = reg_we && (dec_region == RG_RSEL)    && (dec_idx == 8'(t));
      assign ien_wr    = reg_we && (dec_region == RG_IEN)     && (dec_idx == 8'(t));
      assign clr_wr[t] = reg_we && (dec_region == RG_ICLR)    && (dec_idx == 8'(t));
      assign cap_wr[t] = reg_we && (dec_region == RG_CAPTURE) && (dec_idx == 8'(t))
                         && reg_wdata[0] && (req_tgl[t] == ack_seen[t]);

      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
         if (!bus_rst_n) begin
            preload_q[t] <= '0;
            rsel_q[t]    <= '0;
            ien_q[t]     <= '0;
         end else begin
            if (pre_wr) preload_q[t] <= reg_wdata[CNT_W-1:0];
            if (sel_wr) rsel_q[t]    <= reg_wdata[SEL_W-1:0];
            if (ien_wr) ien_q[t]     <= reg_wdata[N_CMP-1:0];
         end
      end

      // sticky flags: a fresh event wins over a clear in the same cycle
      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
         if (!bus_rst_n) begin
            sts_q[t] <= '0;
         end else begin
            sts_q[t] <= (sts_q[t] & ~(clr_wr[t] ? reg_wdata[N_CMP-1:0] : '0)) | evt_pulse[t];
         end
      end

      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
         if (!bus_rst_n) begin
            req_tgl[t]  <= 1'b0;
            ack_seen[t] <= 1'b0;
            cap_q[t]    <= '0;
         end else begin
            if (cap_wr[t]) req_tgl[t] <= ~req_tgl[t];
            if (ack_pulse[t]) begin
               ack_seen[t] <= ~ack_seen[t];
               cap_q[t]    <= snap_fn[t];
            end
         end
      end

      assign irq[t] = |(sts_q[t] & ien_q[t]);

      tmr_bank_tsync #(.STAGES(SYNC_STAGES), .PULSE_OUT(1'b0)) u_en_sync (
         .clk   (fn_clk),
         .rst_n (fn_rst_n),
         .d_in  (en_q[t]),
         .q_out (en_fn[t])
      );

      tmr_bank_tsync #(.STAGES(SYNC_STAGES), .PULSE_OUT(1'b1)) u_req_sync (
         .clk   (fn_clk),
         .rst_n (fn_rst_n),
         .d_in  (req_tgl[t]),
         .q_out (req_pulse_fn[t])
      );

      tmr_bank_tsync #(.STAGES(SYNC_STAGES), .PULSE_OUT(1'b1)) u_ack_sync (
         .clk   (bus_clk),
         .rst_n (bus_rst_n),
         .d_in  (ack_tgl_fn[t]),
         .q_out (ack_pulse[t])
      );

      for (genvar c = 0; c < N_CMP; c++) begin : g_evt
         assign mv[c] = match_q[t*N_CMP + c];

         tmr_bank_tsync #(.STAGES(SYNC_STAGES), .PULSE_OUT(1'b1)) u_evt_sync (
            .clk   (bus_clk),
            .rst_n (bus_rst_n),
            .d_in  (evt_tgl_fn[t][c]),
            .q_out (evt_pulse[t][c])
         );
      end

      tmr_bank_chan #(.CNT_W(CNT_W), .N_CMP(N_CMP), .SEL_W(SEL_W)) u_chan (
         .clk        (fn_clk),
         .rst_n      (fn_rst_n),
         .run        (en_fn[t]),
         .snap_req   (req_pulse_fn[t]),
         .match_vals (mv),
         .preload    (preload_q[t]),
         .rsel       (rsel_q[t]),
         .cnt_q      (cnt_fn[t]),
         .snap_q     (snap_fn[t]),
         .evt_tgl    (evt_tgl_fn[t]),
         .ack_tgl    (ack_tgl_fn[t])
      );
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      case (dec_region)
         RG_MATCH: begin
            for (int m = 0; m < N_MATCH; m++)
               if (dec_idx == 8'(m)) reg_rdata = BUS_W'(match_q[m]);
         end
         RG_PRELOAD: begin
            for (int t = 0; t < N_TMR; t++)
               if (dec_idx == 8'(t)) reg_rdata = BUS_W'(preload_q[t]);
         end
         RG_RSEL: begin
            for (int t = 0; t < N_TMR; t++)
               if (dec_idx == 8'(t)) reg_rdata = BUS_W'(rsel_q[t]);
         end
         RG_ENABLE: reg_rdata = BUS_W'(en_q);
         RG_STATUS: begin
            for (int t = 0; t < N_TMR; t++)
               if (dec_idx == 8'(t)) reg_rdata = BUS_W'(sts_q[t]);
         end
         RG_IEN: begin
            for (int t = 0; t < N_TMR; t++)
               if (dec_idx == 8'(t)) reg_rdata = BUS_W'(ien_q[t]);
         end
         RG_CAPTURE: begin
            for (int t = 0; t < N_TMR; t++)
               if (dec_idx == 8'(t)) reg_rdata = BUS_W'(cap_q[t]);
         end
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
   parameter int unsigned N_TMR = 3,
   parameter int unsigned N_CMP = 3,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned SEL_W = 2
) (
   input logic                                bus_clk,
   input logic                                bus_rst_n,
   input logic                                fn_clk,
   input logic                                fn_rst_n,
   input logic [N_TMR-1:0]                    irq,
   input logic [N_TMR-1:0][N_CMP-1:0]         ien_q,
   input logic [N_TMR-1:0][N_CMP-1:0]         sts_q,
   input logic [N_TMR-1:0]                    clr_wr,
   input logic [N_TMR-1:0]                    ack_pulse,
   input logic [N_TMR-1:0][CNT_W-1:0]         cap_q,
   input logic [N_TMR-1:0]                    en_fn,
   input logic [N_TMR-1:0][SEL_W-1:0]         rsel_q,
   input logic [N_TMR-1:0][CNT_W-1:0]         preload_q,
   input logic [N_TMR-1:0][CNT_W-1:0]         cnt_fn,
   input logic [N_TMR*N_CMP-1:0][CNT_W-1:0]   match_q
);

   for (genvar t = 0; t < N_TMR; t++) begin : g_t
      // R2
      cnt_hold_chk: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
         !en_fn[t] |=> $stable(cnt_fn[t]));

      // R2
      cnt_step_chk: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
         (en_fn[t] && (rsel_q[t] == '0)) |=> (cnt_fn[t] == CNT_W'($past(cnt_fn[t]) + 1)));

      // R3
      reload_cmp0_chk: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
         (en_fn[t] && (rsel_q[t] == SEL_W'(1)) && (cnt_fn[t] == match_q[t*N_CMP]))
         |=> (cnt_fn[t] == $past(preload_q[t])));

      // R5
      sts_sticky_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
         !clr_wr[t] |=> ((sts_q[t] & $past(sts_q[t])) == $past(sts_q[t])));

      // R6
      irq_masked_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
         (ien_q[t] == '0) |-> !irq[t]);

      // R7
      cap_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
         !ack_pulse[t] |=> $stable(cap_q[t]));
   end

endmodule

bind tmr_bank tmr_bank_chk #(
   .N_TMR (N_TMR),
   .N_CMP (N_CMP),
   .CNT_W (CNT_W),
   .SEL_W (SEL_W)
) u_chk (
   .bus_clk   (bus_clk),
   .bus_rst_n (bus_rst_n),
   .fn_clk    (fn_clk),
   .fn_rst_n  (fn_rst_n),
   .irq       (irq),
   .ien_q     (ien_q),
   .sts_q     (sts_q),
   .clr_wr    (clr_wr),
   .ack_pulse (ack_pulse),
   .cap_q     (cap_q),
   .en_fn     (en_fn),
   .rsel_q    (rsel_q),
   .preload_q (preload_q),
   .cnt_fn    (cnt_fn),
   .match_q   (match_q)
);

// File: tb/tb_tmr_bank.sv
`timescale 1ns/1ps
module tb_tmr_bank;

   localparam int A_MATCH = 0;
   localparam int A_PRE   = 9;
   localparam int A_SEL   = 12;
   localparam int A_EN    = 15;
   localparam int A_STS   = 16;
   localparam int A_IEN   = 19;
   localparam int A_CLR   = 22;
   localparam int A_CAP   = 25;
   localparam int N_ADDR  = 28;

   logic        bus_clk = 1'b0;
   logic        fn_clk  = 1'b0;
   logic        bus_rst_n = 1'b0;
   logic        fn_rst_n  = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 bus_clk = ~bus_clk;
   always #20  fn_clk  = ~fn_clk;

   tmr_bank dut (
      .bus_clk   (bus_clk),
      .bus_rst_n (bus_rst_n),
      .fn_clk    (fn_clk),
      .fn_rst_n  (fn_rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   typedef struct packed {
      logic [5:0]  a;
      logic [31:0] w;
      logic [31:0] e;
      logic [3:0]  r;
   } vec_t;

   // write-then-read vectors: R9 masking and read-only behaviour, R7 ignored request
   localparam vec_t VECS [8] = '{
      '{6'd0,  32'h1234_5678, 32'h1234_5678, 4'd9},
      '{6'd9,  32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd9},
      '{6'd12, 32'hFFFF_FFFF, 32'h0000_0003, 4'd9},
      '{6'd15, 32'hFFFF_FFF8, 32'h0000_0000, 4'd9},
      '{6'd16, 32'h0000_0007, 32'h0000_0000, 4'd9},
      '{6'd19, 32'hFFFF_FFFE, 32'h0000_0006, 4'd9},
      '{6'd22, 32'h0000_0007, 32'h0000_0000, 4'd9},
      '{6'd25, 32'h0000_0000, 32'h0000_0000, 4'd7}
   };

   task automatic report(input string req, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge bus_clk);
      reg_we    = 1'b1;
      reg_addr  = 6'(a);
      reg_wdata = d;
      @(negedge bus_clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge bus_clk);
      reg_addr = 6'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_fn(input int n);
      repeat (n) @(posedge fn_clk);
   endtask

   task automatic capture(input int t, output logic [31:0] d);
      wr(A_CAP + t, 32'h1);
      wait_fn(12);
      rd(A_CAP + t, d);
   endtask

   initial begin
      #500us;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v0, v1, a2, v2;
      repeat (10) @(posedge bus_clk);
      wait_fn(2);
      @(negedge bus_clk);
      bus_rst_n = 1'b1;
      fn_rst_n  = 1'b1;
      wait_fn(2);

      // R1: every address reads zero after reset
      for (int a = 0; a < N_ADDR; a++) begin
         rd(a, v);
         report("R1", v == 32'h0, v, 32'h0, "reset read");
      end
      report("R1", irq == 3'b000, 32'(irq), 32'h0, "reset irq");

      // R9 / R7 vector table
      for (int i = 0; i < 8; i++) begin
         wr(int'(VECS[i].a), VECS[i].w);
         wait_fn(1);
         rd(int'(VECS[i].a), v);
         report($sformatf("R%0d", VECS[i].r), v == VECS[i].e, v, VECS[i].e,
                $sformatf("vector %0d", i));
      end
      wr(A_MATCH, 0);
      wr(A_PRE, 0);
      wr(A_SEL, 0);
      wr(A_IEN, 0);

      // counter 0: no reload (R3 value 0), count window (R2)
      wr(A_MATCH + 0, 5);
      wr(A_MATCH + 1, 1000);
      wr(A_MATCH + 2, 2000);
      wr(A_EN, 32'h1);
      wait_fn(20);
      wr(A_EN, 32'h0);
      wait_fn(6);
      capture(0, v0);
      report("R2", (v0 >= 19) && (v0 <= 21), v0, 32'd20, "count over 20 edges");
      report("R3", v0 > 5, v0, 32'd6, "selector 0 passes match without reload");
      wait_fn(8);
      capture(0, v);
      report("R2", v == v0, v, v0, "stopped counter holds");
      wr(A_CAP + 0, 32'h2);
      wait_fn(12);
      rd(A_CAP + 0, v);
      report("R7", v == v0, v, v0, "bit0=0 capture write ignored");

      // R5 / R6 on counter 0
      rd(A_STS + 0, v);
      report("R5", v == 32'h1, v, 32'h1, "comparator 0 flag only");
      report("R6", irq[0] == 1'b0, 32'(irq[0]), 32'h0, "irq masked");
      wr(A_IEN + 0, 32'h1);
      report("R6", irq[0] == 1'b1, 32'(irq[0]), 32'h1, "irq enabled");
      wr(A_IEN + 0, 32'h6);
      report("R6", irq[0] == 1'b0, 32'(irq[0]), 32'h0, "other enables only");
      wr(A_IEN + 0, 32'h1);
      wr(A_CLR + 0, 32'h6);
      rd(A_STS + 0, v);
      report("R5", v == 32'h1, v, 32'h1, "clear of zero bits leaves flag");
      report("R6", irq[0] == 1'b1, 32'(irq[0]), 32'h1, "irq still high");
      wr(A_CLR + 0, 32'h1);
      rd(A_STS + 0, v);
      report("R5", v == 32'h0, v, 32'h0, "clear bit 0");
      report("R6", irq[0] == 1'b0, 32'(irq[0]), 32'h0, "irq after clear");
      rd(A_CLR + 0, v);
      report("R9", v == 32'h0, v, 32'h0, "clear reads zero");

      // counter 1: reload on comparator 1, passes through all ones (R4, R3)
      wr(A_MATCH + 3, 32'hFFFF_FFFF);
      wr(A_MATCH + 4, 32'h3);
      wr(A_MATCH + 5, 32'h8000_0000);
      wr(A_PRE + 1, 32'hFFFF_FFF0);
      wr(A_SEL + 1, 32'h2);
      wr(A_EN, 32'h2);
      wait_fn(45);
      wr(A_EN, 32'h0);
      wait_fn(6);
      capture(1, v1);
      report("R4", (v1 >= 32'hFFFF_FFF0) || (v1 <= 32'h3), v1, 32'hFFFF_FFF0,
             "count inside wrap window");
      rd(A_STS + 1, v);
      report("R4", v == 32'h3, v, 32'h3, "all-ones match and reload match flagged");
      capture(0, v);
      report("R8", v == v0, v, v0, "counter 0 untouched");
      capture(2, v);
      report("R8", v == 32'h0, v, 32'h0, "counter 2 untouched");

      // counter 2: reload on comparator 0 (R3), snapshot stability (R7)
      wr(A_MATCH + 6, 103);
      wr(A_MATCH + 7, 500);
      wr(A_MATCH + 8, 500);
      wr(A_PRE + 2, 100);
      wr(A_SEL + 2, 32'h1);
      wr(A_EN, 32'h4);
      wait_fn(30);
      capture(2, a2);
      report("R7", (a2 >= 32'd1) && (a2 <= 32'd103), a2, 32'd103, "running snapshot in range");
      wait_fn(10);
      rd(A_CAP + 2, v);
      report("R7", v == a2, v, a2, "snapshot holds while counting");
      wait_fn(120);
      wr(A_EN, 32'h0);
      wait_fn(6);
      capture(2, v2);
      report("R3", (v2 >= 32'd100) && (v2 <= 32'd103), v2, 32'd100, "reload window");
      rd(A_STS + 2, v);
      report("R5", v == 32'h1, v, 32'h1, "counter 2 flags");
      report("R6", irq[2] == 1'b0, 32'(irq[2]), 32'h0, "counter 2 irq masked");
      capture(1, v);
      report("R8", v == v1, v, v1, "counter 1 untouched");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule